// File: doc/BRIEF.md
# Adaptive Delay Synchronizer

This block moves a bundled data word, marked by a one-cycle strobe, from a transmit domain into a receive domain whose clock runs at nearly the same rate. It does not use a fixed flop chain. The word and its strobe pass through a selectable tap chain, so that data transitions can be steered away from the receive clock's rising edge. The tap chain is a shift register clocked by a fast oversampling clock `clk`. The receive clock `rxClk` is sampled as a level in that fast domain. All timing below is counted in fast cycles.

Two window detectors compare delayed transitions with the receive clock. One watches the rising edge (the 0° point). The other watches the falling edge (the 180° point). A small control machine reads both flags at each receive rising edge. It can move the tap in only two ways: a clear back to tap 0, or a one-tap increment. The adaptation goal is selectable. It can move data away from the 0° edge, or it can land data on the 180° point. Adaptation runs either all the time or only during a training session. The block reports lock once the selected goal has held for a run of receive cycles.

Top module: `adaptive_delay_sync`

## Requirements
- R1: The word and strobe sampled at fast edge m appear at tap t during fast cycle m+t. A receive edge is the fast cycle in which a newly sampled high `rxClk` first appears, following a sampled low.
- R2: A 0° conflict exists when a delayed strobe lands within WIN (default 2) fast cycles of a receive rising edge, on either side.
- R3: A 180° conflict is judged the same way, measured against the receive falling edge (the first sampled low after a high).
- R4: Reset leaves the tap at 0. Afterwards the tap changes only by a clear to 0 or by a step of exactly +1.
- R5: An increment from the last tap (TAPS-1, default 15) wraps to 0 and sets `tapOverflow`. This flag stays high until reset.
- R6: After any tap change or clear, the next SETTLE (default 2) receive edges are not evaluated. The first evaluation comes on the edge after them.
- R7: With `snapMode`=0, an evaluation passes when no 0° conflict was seen since the previous receive edge. A failing evaluation increments the tap while adaptation is enabled.
- R8: With `snapMode`=1, an evaluation passes only when a 180° conflict was seen and no 0° conflict was seen. A failure increments the tap as in R7.
- R9: `locked` rises after LOCK_CNT (default 8) consecutive passing evaluations. Any failing evaluation drops it.
- R10: With `trainSel`=0, adaptation is always on. With `trainSel`=1 and `trainActive`=0, the tap is frozen, but failing evaluations still drop lock.
- R11: A rise of `trainActive` while `trainSel`=1 clears the tap to 0, drops lock and restarts the settle wait.
- R12: At each receive edge, `rxData` captures the word at the selected tap. While `trainSel`=1, `trainActive`=1 and `locked`=0, it holds its value.
- R13: After reset, `rxData` is 0 and `locked` and `tapOverflow` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast oversampling clock |
| rstN | input | 1 | Active-low asynchronous reset |
| txData | input | DATA_W | Bundled transmit word |
| txValid | input | 1 | One-cycle strobe marking a new transmit word |
| rxClk | input | 1 | Receive clock, sampled as a level |
| snapMode | input | 1 | 0: keep clear of the 0° edge; 1: land on the 180° point |
| trainSel | input | 1 | 0: continuous adaptation; 1: adapt only during training |
| trainActive | input | 1 | Training session in progress |
| tapIdx | output | TAP_W | Currently selected delay tap |
| rxData | output | DATA_W | Word captured in the receive domain |
| locked | output | 1 | Adaptation goal held for LOCK_CNT evaluations |
| tapOverflow | output | 1 | Sticky flag: the tap wrapped past the last position |

## Verification
The hardest case to reach is tap wrap-around, together with the settle spacing between successive increments. In normal traffic the machine finds a passing tap well before the last one. To force a wrap, the bench runs snap mode with the transmit strobes stopped, so no 180° conflict can ever occur. Every evaluation then fails, and the tap walks through every position until it wraps. The settle spacing is caught by a phase shift in the data: the bench waits for the first tap step, then samples the tap one period before the next permitted step and again just after it.

// File: rtl/adsync_pkg.sv
package adsync_pkg;

  typedef struct packed {
    logic tapClear;
    logic tapInc;
    logic captureEn;
  } tapCmd_t;

  typedef struct packed {
    logic evalStrobe;
    logic conf0;
    logic conf180;
  } confInfo_t;

  typedef enum logic [1:0] {
    ST_SETTLE = 2'd0,
    ST_HUNT   = 2'd1,
    ST_LOCK   = 2'd2
  } adaptState_t;

endpackage

// File: rtl/adsync_delay_line.sv
module adsync_delay_line #(
  parameter int DATA_W = 8,
  parameter int TAPS   = 16,
  localparam int TAP_W = $clog2(TAPS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W:0]   inWord,
  input  logic [TAP_W-1:0]  tapSel,
  output logic [DATA_W:0]   tapWord
);

  logic [DATA_W:0] stage [TAPS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stage[0] <= '0;
    else       stage[0] <= inWord;
  end

  for (genvar k = 1; k < TAPS; k++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stage[k] <= '0;
      else       stage[k] <= stage[k-1];
    end
  end

  assign tapWord = stage[tapSel];

endmodule

// File: rtl/adsync_conflict_det.sv
module adsync_conflict_det #(
  parameter int WIN = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic edgeEv,
  input  logic transEv,
  input  logic evalStrobe,
  output logic conflict
);

  logic [WIN-1:0] edgeHist;
  logic [WIN-1:0] transHist;
  logic           hitNow;
  logic           accum;

  if (WIN == 1) begin : g_hist1
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        edgeHist  <= '0;
        transHist <= '0;
      end else begin
        edgeHist  <= edgeEv;
        transHist <= transEv;
      end
    end
  end else begin : g_histN
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        edgeHist  <= '0;
        transHist <= '0;
      end else begin
        edgeHist  <= {edgeHist[WIN-2:0], edgeEv};
        transHist <= {transHist[WIN-2:0], transEv};
      end
    end
  end

  // Edge after a recent transition, or transition after a recent edge.
  assign hitNow = (edgeEv && (transEv || (|transHist))) || (transEv && (|edgeHist));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           accum <= 1'b0;
    else if (evalStrobe) accum <= 1'b0;
    else                 accum <= accum | hitNow;
  end

  assign conflict = accum | hitNow;

endmodule

// File: rtl/adsync_datapath.sv
module adsync_datapath
  import adsync_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int TAPS   = 16,
  parameter int WIN    = 2,
  localparam int TAP_W = $clog2(TAPS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] txData,
  input  logic              txValid,
  input  logic              rxClk,
  input  tapCmd_t           cmd,
  output confInfo_t         conf,
  output logic [TAP_W-1:0]  tapIdx,
  output logic              tapOverflow,
  output logic [DATA_W-1:0] rxData
);

  logic [DATA_W:0] tapWord;
  logic            rxQ1;
  logic            rxQ2;
  logic            rxRise;
  logic            rxFall;
  logic            delValid;
  logic            hit0;
  logic            hit180;

  adsync_delay_line #(.DATA_W(DATA_W), .TAPS(TAPS)) line_i (
    .clk    (clk),
    .rstN   (rstN),
    .inWord ({txValid, txData}),
    .tapSel (tapIdx),
    .tapWord(tapWord)
  );

  assign delValid = tapWord[DATA_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxQ1 <= 1'b0;
      rxQ2 <= 1'b0;
    end else begin
      rxQ1 <= rxClk;
      rxQ2 <= rxQ1;
    end
  end

  assign rxRise = rxQ1 & ~rxQ2;
  assign rxFall = ~rxQ1 & rxQ2;

  adsync_conflict_det #(.WIN(WIN)) det0_i (
    .clk       (clk),
    .rstN      (rstN),
    .edgeEv    (rxRise),
    .transEv   (delValid),
    .evalStrobe(rxRise),
    .conflict  (hit0)
  );

  adsync_conflict_det #(.WIN(WIN)) det180_i (
    .clk       (clk),
    .rstN      (rstN),
    .edgeEv    (rxFall),
    .transEv   (delValid),
    .evalStrobe(rxRise),
    .conflict  (hit180)
  );

  assign conf.evalStrobe = rxRise;
  assign conf.conf0      = hit0;
  assign conf.conf180    = hit180;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tapIdx      <= '0;
      tapOverflow <= 1'b0;
    end else if (cmd.tapClear) begin
      tapIdx <= '0;
    end else if (cmd.tapInc) begin
      if (tapIdx == TAP_W'(TAPS - 1)) begin
        tapIdx      <= '0;
        tapOverflow <= 1'b1;
      end else begin
        tapIdx <= tapIdx + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        rxData <= '0;
    else if (rxRise && cmd.captureEn) rxData <= tapWord[DATA_W-1:0];
  end

endmodule

// File: rtl/adsync_ctrl.sv
module adsync_ctrl
  import adsync_pkg::*;
#(
  parameter int LOCK_CNT = 8,
  parameter int SETTLE   = 2,
  localparam int LOCK_W  = $clog2(LOCK_CNT + 1),
  localparam int SET_W   = $clog2(SETTLE + 1)
) (
  input  logic      clk,
  input  logic      rstN,
  input  confInfo_t conf,
  input  logic      snapMode,
  input  logic      trainSel,
  input  logic      trainActive,
  output tapCmd_t   cmd,
  output logic      locked
);

  adaptState_t       state, stateN;
  logic [SET_W-1:0]  settleCnt, settleN;
  logic [LOCK_W-1:0] goodCnt, goodN;
  logic              trainPrev;
  logic              sessionStart;
  logic              adaptOn;
  logic              evalGood;

  assign sessionStart = trainSel & trainActive & ~trainPrev;
  assign adaptOn      = ~trainSel | trainActive;
  assign evalGood     = snapMode ? (conf.conf180 & ~conf.conf0) : ~conf.conf0;
  assign locked       = (state == ST_LOCK);

  always_comb begin
    stateN        = state;
    settleN       = settleCnt;
    goodN         = goodCnt;
    cmd.tapClear  = 1'b0;
    cmd.tapInc    = 1'b0;
    cmd.captureEn = ~(trainSel & trainActive & ~locked);
    if (sessionStart) begin
      cmd.tapClear = 1'b1;
      stateN       = ST_SETTLE;
      settleN      = SET_W'(SETTLE);
      goodN        = '0;
    end else if (conf.evalStrobe) begin
      case (state)
        ST_SETTLE: begin
          if (settleCnt <= SET_W'(1)) stateN = ST_HUNT;
          settleN = settleCnt - 1'b1;
        end
        default: begin
          if (evalGood) begin
            if (state != ST_LOCK) begin
              if (goodCnt == LOCK_W'(LOCK_CNT - 1)) stateN = ST_LOCK;
              else                                  goodN  = goodCnt + 1'b1;
            end
          end else begin
            goodN = '0;
            if (adaptOn) begin
              cmd.tapInc = 1'b1;
              stateN     = ST_SETTLE;
              settleN    = SET_W'(SETTLE);
            end else begin
              stateN = ST_HUNT;
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_SETTLE;
      settleCnt <= SET_W'(SETTLE);
      goodCnt   <= '0;
      trainPrev <= 1'b0;
    end else begin
      state     <= stateN;
      settleCnt <= settleN;
      goodCnt   <= goodN;
      trainPrev <= trainActive;
    end
  end

endmodule

// File: rtl/adaptive_delay_sync.sv
module adaptive_delay_sync
  import adsync_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int TAPS     = 16,
  parameter int WIN      = 2,
  parameter int LOCK_CNT = 8,
  parameter int SETTLE   = 2,
  localparam int TAP_W   = $clog2(TAPS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] txData,
  input  logic              txValid,
  input  logic              rxClk,
  input  logic              snapMode,
  input  logic              trainSel,
  input  logic              trainActive,
  output logic [TAP_W-1:0]  tapIdx,
  output logic [DATA_W-1:0] rxData,
  output logic              locked,
  output logic              tapOverflow
);

  tapCmd_t   cmdBus;
  confInfo_t confBus;

  adsync_datapath #(.DATA_W(DATA_W), .TAPS(TAPS), .WIN(WIN)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .txData     (txData),
    .txValid    (txValid),
    .rxClk      (rxClk),
    .cmd        (cmdBus),
    .conf       (confBus),
    .tapIdx     (tapIdx),
    .tapOverflow(tapOverflow),
    .rxData     (rxData)
  );

  adsync_ctrl #(.LOCK_CNT(LOCK_CNT), .SETTLE(SETTLE)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .conf       (confBus),
    .snapMode   (snapMode),
    .trainSel   (trainSel),
    .trainActive(trainActive),
    .cmd        (cmdBus),
    .locked     (locked)
  );

endmodule

// File: rtl/adsync_checker.sv
module adsync_checker #(
  parameter int DATA_W = 8,
  parameter int TAPS   = 16,
  parameter int SETTLE = 2,
  localparam int TAP_W = $clog2(TAPS),
  localparam int CNT_W = $clog2(SETTLE + 2)
) (
  input logic              clk,
  input logic              rstN,
  input logic [TAP_W-1:0]  tapIdx,
  input logic [DATA_W-1:0] rxData,
  input logic              locked,
  input logic              tapOverflow,
  input logic              trainSel,
  input logic              trainActive,
  input logic              tapInc,
  input logic              tapClear,
  input logic              evalStrobe,
  input logic              conf0
);

  logic [TAP_W-1:0] prevTap;
  logic [CNT_W-1:0] risesSince;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevTap    <= '0;
      risesSince <= '0;
    end else begin
      prevTap <= tapIdx;
      if (tapIdx != prevTap)
        risesSince <= '0;
      else if (evalStrobe && risesSince < CNT_W'(SETTLE))
        risesSince <= risesSince + 1'b1;
    end
  end

  p_tap_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (tapIdx != $past(tapIdx)) |-> (tapIdx == '0 || tapIdx == $past(tapIdx) + 1'b1));

  p_wrap_flag_r5: assert property (@(posedge clk) disable iff (!rstN)
    (tapInc && !tapClear && tapIdx == TAP_W'(TAPS - 1)) |=> (tapOverflow && tapIdx == '0));

  p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    tapOverflow |=> tapOverflow);

  p_settle_gap_r6: assert property (@(posedge clk) disable iff (!rstN)
    tapInc |-> (risesSince >= CNT_W'(SETTLE)));

  p_lock_on_eval_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(locked) |-> $past(evalStrobe));

  p_lock_drop_r9: assert property (@(posedge clk) disable iff (!rstN)
    (locked && evalStrobe && conf0) |=> !locked);

  p_frozen_r10: assert property (@(posedge clk) disable iff (!rstN)
    (trainSel && !trainActive) |=> $stable(tapIdx));

  p_clear_r11: assert property (@(posedge clk) disable iff (!rstN)
    tapClear |=> (tapIdx == '0 && !locked));

  p_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    (trainSel && trainActive && !locked) |=> $stable(rxData));

endmodule

bind adaptive_delay_sync adsync_checker #(
  .DATA_W(DATA_W),
  .TAPS  (TAPS),
  .SETTLE(SETTLE)
) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .tapIdx     (tapIdx),
  .rxData     (rxData),
  .locked     (locked),
  .tapOverflow(tapOverflow),
  .trainSel   (trainSel),
  .trainActive(trainActive),
  .tapInc     (cmdBus.tapInc),
  .tapClear   (cmdBus.tapClear),
  .evalStrobe (confBus.evalStrobe),
  .conf0      (confBus.conf0)
);

// File: tb/adaptive_delay_sync_tb_top.sv
module adaptive_delay_sync_tb_top;

  localparam int DATA_W = 8;
  localparam int TAP_W  = 4;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [DATA_W-1:0] txData = '0;
  logic              txValid = 1'b0;
  logic              rxClk = 1'b0;
  logic              snapMode = 1'b0;
  logic              trainSel = 1'b0;
  logic              trainActive = 1'b0;
  logic [TAP_W-1:0]  tapIdx;
  logic [DATA_W-1:0] rxData;
  logic              locked;
  logic              tapOverflow;

  logic [3:0]        phaseCnt = '0;
  logic [3:0]        txOff = 4'd5;
  logic              txRun = 1'b0;
  logic [DATA_W-1:0] lastWord = '0;
  logic [DATA_W-1:0] prevWord = '0;

  int nChecks = 0;
  int nFails  = 0;

  always #2 clk = ~clk;

  adaptive_delay_sync dut_i (
    .clk        (clk),
    .rstN       (rstN),
    .txData     (txData),
    .txValid    (txValid),
    .rxClk      (rxClk),
    .snapMode   (snapMode),
    .trainSel   (trainSel),
    .trainActive(trainActive),
    .tapIdx     (tapIdx),
    .rxData     (rxData),
    .locked     (locked),
    .tapOverflow(tapOverflow)
  );

  // Stimulus frame: 16 fast cycles per receive period, rxClk high for 8.
  always @(negedge clk) begin
    logic [3:0] nextPh;
    nextPh   = phaseCnt + 4'd1;
    phaseCnt <= nextPh;
    rxClk    <= rstN && (nextPh < 4'd8);
    if (txRun && nextPh == txOff) begin
      txValid  <= 1'b1;
      txData   <= lastWord + 8'd1;
      prevWord <= lastWord;
      lastWord <= lastWord + 8'd1;
    end else begin
      txValid <= 1'b0;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic testReset();
    waitCycles(3);
    check(tapIdx == 0, "R13 tap after reset", tapIdx, 0);
    check(rxData == 0, "R13 rxData after reset", rxData, 0);
    check(locked == 0, "R13 locked after reset", locked, 0);
    check(tapOverflow == 0, "R13 overflow after reset", tapOverflow, 0);
  endtask

  task automatic testAvoidClear();
    // offset 5 at tap 0: no 0-degree conflict (R2), stays on tap 0
    txOff = 4'd5; txRun = 1'b1;
    waitCycles(40 * 16);
    check(tapIdx == 0, "R7 avoid mode keeps clean tap", tapIdx, 0);
    check(locked == 1, "R9 lock after clean run", locked, 1);
    check(rxData == lastWord || rxData == prevWord, "R1 R12 captured word", rxData, lastWord);
  endtask

  task automatic testLockDropSettle();
    int guard;
    txOff = 4'd0;
    guard = 0;
    while (tapIdx == 0 && guard < 200) begin
      waitCycles(1);
      guard++;
    end
    check(tapIdx == 1, "R2 R7 conflict steps tap", tapIdx, 1);
    check(locked == 0, "R9 lock dropped on conflict", locked, 0);
    waitCycles(39);
    check(tapIdx == 1, "R6 no step during settle", tapIdx, 1);
    waitCycles(16);
    check(tapIdx == 2, "R6 step after settle", tapIdx, 2);
    waitCycles(40 * 16);
    check(tapIdx == 3, "R2 window edge at 2 cycles", tapIdx, 3);
    check(locked == 1, "R9 relock", locked, 1);
  endtask

  task automatic testFrozen();
    trainSel = 1'b1; trainActive = 1'b0; txOff = 4'd14;
    waitCycles(20 * 16);
    check(tapIdx == 3, "R10 tap frozen outside session", tapIdx, 3);
    check(locked == 0, "R10 lock dropped while frozen", locked, 0);
  endtask

  task automatic testSession();
    logic [DATA_W-1:0] held;
    held = rxData;
    trainActive = 1'b1;
    waitCycles(40);
    check(tapIdx == 0, "R11 session start clears tap", tapIdx, 0);
    check(locked == 0, "R11 lock cleared at session", locked, 0);
    check(rxData == held, "R12 output held in training", rxData, held);
    waitCycles(40 * 16);
    check(tapIdx == 5, "R7 training finds tap", tapIdx, 5);
    check(locked == 1, "R9 training lock", locked, 1);
    check(rxData != held, "R12 output released after lock", rxData, held + 1);
  endtask

  task automatic testSnap();
    trainSel = 1'b0; trainActive = 1'b0; snapMode = 1'b1; txOff = 4'd0;
    waitCycles(40 * 16);
    check(tapIdx == 6, "R8 R3 snap to falling edge", tapIdx, 6);
    check(locked == 1, "R8 snap lock", locked, 1);
    check(tapOverflow == 0, "R5 no overflow without wrap", tapOverflow, 0);
  endtask

  task automatic testWrap();
    txRun = 1'b0;
    waitCycles(55 * 16);
    check(tapOverflow == 1, "R5 wrap sets overflow", tapOverflow, 1);
    check(locked == 0, "R8 no lock without 180 conflict", locked, 0);
    snapMode = 1'b0;
    waitCycles(20 * 16);
    check(locked == 1, "R7 lock with no conflicts", locked, 1);
    check(tapOverflow == 1, "R5 overflow sticky", tapOverflow, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog timeout actual=%0d expected=%0d", 150000, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    testReset();
    testAvoidClear();
    testLockDropSettle();
    testFrozen();
    testSession();
    testSnap();
    testWrap();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule